// File: doc/BRIEF.md
# DDR Command-Slot Control Word Packer

This block sits between a DDR2/DDR3 command scheduler and a physical layer that runs at one quarter of the memory clock. On every PHY clock cycle it offers four command lanes to the scheduler. Lane 0 is the earliest memory-clock slot of the group and lane 3 the latest. It registers the lanes it accepts into one control word. Lanes with nothing to send become NOP slots. Each word carries a two-bit group tag that wraps, so that several byte-lane PHY controllers fed from copies of the same stream stay aligned.

Each word also carries a class field: write, read, or non-data. A group may hold reads or writes but never both. When a lane would bring in the opposite data direction from an earlier accepted lane, that lane is refused. Every lane after it is refused too, so the scheduler resubmits them in the next group and command order is kept. The write strobe into the downstream control FIFO is tied high, because a word leaves every cycle. The DRAM reset line is not part of the word. It is passed straight through as its own pin.

Command encoding is {RAS_n, CAS_n, WE_n}: NOP = 3'b111, write = 3'b100, read = 3'b101. Any other value, such as activate 3'b011, is a non-data command.

Top module: `ddr_slot_packer`

## Requirements
- R1: `ctl_word` takes a new value on every rising clock edge, and `ctl_wr_en` is 1 in every cycle, including during reset.
- R2: A lane i that is valid and ready in cycle N appears in cycle N+1 as slot i. Slot i sits in `ctl_word[8*i+7 : 8*i]`, with the command in bits [2:0] of the slot and the select in bits [7:3].
- R3: A slot whose lane was not valid, or was not accepted, holds the NOP slot value 8'h07: command 3'b111 with select 0.
- R4: The sequence tag in `ctl_word[35:34]` is 0 after reset. It increases by one on every clock edge out of reset and wraps from 3 to 0. The first word after reset is released carries tag 1.
- R5: The class field in `ctl_word[33:32]` is 2'b01 when any slot holds a write, 2'b10 when any slot holds a read, and 2'b00 otherwise. It is never 2'b11.
- R6: A valid lane whose command is the opposite data direction to a write or read accepted in an earlier lane of the same cycle has `req_ready` low.
- R7: Once a lane is refused, every later lane in the same cycle has `req_ready` low, whatever it carries. When lanes are refused this way, `req_ready` forms a contiguous run of ones starting at lane 0.
- R8: While `rst` is high, `req_ready` is 0. At the next edge the word becomes all-NOP with class 2'b00 and tag 0.
- R9: `dram_rst_n` is the inverse of `dram_rst_in` at all times, independent of `rst` and of the command lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Per-lane command valid |
| req_cmd | input | 12 | Per-lane command {RAS_n,CAS_n,WE_n}, lane i at [3i+2:3i] |
| req_sel | input | 20 | Per-lane bank/rank select, lane i at [5i+4:5i] |
| req_ready | output | 4 | Per-lane accept |
| ctl_word | output | 36 | {tag[1:0], class[1:0], slot3, slot2, slot1, slot0} |
| ctl_wr_en | output | 1 | Control FIFO write strobe, always 1 |
| dram_rst_in | input | 1 | DRAM reset request from fabric logic |
| dram_rst_n | output | 1 | Active-low DRAM reset pin |

## Verification
The assertions assume that the lane inputs are held stable across each rising edge, because `req_ready` is a combinational function of them. They also assume that reset is high from time zero. The bench changes lane inputs only on falling edges and holds reset high from the start. Within that envelope it sweeps every mix of none, write, read and activate over the four lanes, with changing selects, so that every position at which a direction conflict can arise is covered.

// File: rtl/ddr_slot_packer.sv
module ddr_slot_packer #(
  parameter int LANES = 4,
  parameter int CMD_W = 3,
  parameter int SEL_W = 5,
  parameter int SEQ_W = 2,
  parameter logic [CMD_W-1:0] CMD_NOP = 3'b111,
  parameter logic [CMD_W-1:0] CMD_WR  = 3'b100,
  parameter logic [CMD_W-1:0] CMD_RD  = 3'b101
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         req_valid,
  input  logic [LANES*CMD_W-1:0]   req_cmd,
  input  logic [LANES*SEL_W-1:0]   req_sel,
  output logic [LANES-1:0]         req_ready,
  output logic [LANES*(CMD_W+SEL_W)+2+SEQ_W-1:0] ctl_word,
  output logic                     ctl_wr_en,
  input  logic                     dram_rst_in,
  output logic                     dram_rst_n
);
  localparam int SLOT_W = CMD_W + SEL_W;
  localparam int BODY_W = LANES * SLOT_W;
  localparam logic [SLOT_W-1:0] NOP_SLOT = {{SEL_W{1'b0}}, CMD_NOP};
  localparam logic [1:0] CLS_NONE = 2'b00, CLS_WR = 2'b01, CLS_RD = 2'b10;

  logic [BODY_W-1:0] body_d, body_q;
  logic [1:0]        cls_d, cls_q;
  logic [SEQ_W-1:0]  seq_q;

  always_comb begin
    logic blocked, has_wr, has_rd, is_wr, is_rd, clash;
    blocked = rst;
    has_wr  = 1'b0;
    has_rd  = 1'b0;
    body_d  = {LANES{NOP_SLOT}};
    req_ready = '0;
    for (int i = 0; i < LANES; i++) begin
      is_wr = req_valid[i] && (req_cmd[i*CMD_W +: CMD_W] == CMD_WR);
      is_rd = req_valid[i] && (req_cmd[i*CMD_W +: CMD_W] == CMD_RD);
      clash = (is_wr && has_rd) || (is_rd && has_wr);
      req_ready[i] = !blocked && !clash;
      if (req_valid[i] && req_ready[i]) begin
        body_d[i*SLOT_W +: SLOT_W] = {req_sel[i*SEL_W +: SEL_W], req_cmd[i*CMD_W +: CMD_W]};
        has_wr = has_wr || is_wr;
        has_rd = has_rd || is_rd;
      end else if (req_valid[i]) begin
        blocked = 1'b1;
      end
    end
    cls_d = has_wr ? CLS_WR : (has_rd ? CLS_RD : CLS_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      body_q <= {LANES{NOP_SLOT}};
      cls_q  <= CLS_NONE;
      seq_q  <= '0;
    end else begin
      body_q <= body_d;
      cls_q  <= cls_d;
      seq_q  <= seq_q + 1'b1;
    end
  end

  assign ctl_word   = {seq_q, cls_q, body_q};
  assign ctl_wr_en  = 1'b1;
  assign dram_rst_n = ~dram_rst_in;
endmodule

// File: rtl/ddr_slot_packer_chk.sv
module ddr_slot_packer_chk #(
  parameter int LANES = 4,
  parameter int CMD_W = 3,
  parameter int SEL_W = 5,
  parameter int SEQ_W = 2,
  parameter logic [CMD_W-1:0] CMD_NOP = 3'b111,
  parameter logic [CMD_W-1:0] CMD_WR  = 3'b100,
  parameter logic [CMD_W-1:0] CMD_RD  = 3'b101
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES-1:0]       req_valid,
  input logic [LANES*CMD_W-1:0] req_cmd,
  input logic [LANES*SEL_W-1:0] req_sel,
  input logic [LANES-1:0]       req_ready,
  input logic [LANES*(CMD_W+SEL_W)+2+SEQ_W-1:0] ctl_word
);
  localparam int SLOT_W = CMD_W + SEL_W;
  localparam int BODY_W = LANES * SLOT_W;
  localparam logic [SLOT_W-1:0] NOP_SLOT = {{SEL_W{1'b0}}, CMD_NOP};

  logic [SEQ_W-1:0] seq;
  logic [1:0]       cls;
  logic             any_wr, any_rd;

  assign seq = ctl_word[BODY_W+2 +: SEQ_W];
  assign cls = ctl_word[BODY_W +: 2];

  always_comb begin
    any_wr = 1'b0;
    any_rd = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      any_wr = any_wr || (ctl_word[i*SLOT_W +: CMD_W] == CMD_WR);
      any_rd = any_rd || (ctl_word[i*SLOT_W +: CMD_W] == CMD_RD);
    end
  end

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> seq == SEQ_W'($past(seq) + 1'b1));

  assert_class_match_R5: assert property (@(posedge clk) disable iff (rst)
    !(any_wr && any_rd) && ((cls == 2'b01) == any_wr) && ((cls == 2'b10) == any_rd)
    && (cls != 2'b11));

  assert_reset_word_R8: assert property (@(posedge clk)
    rst |=> (ctl_word == {{SEQ_W{1'b0}}, 2'b00, {LANES{NOP_SLOT}}}));

  assert_reset_ready_R8: assert property (@(posedge clk)
    rst |-> req_ready == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assert_lane_load_R2: assert property (@(posedge clk) disable iff (rst)
      (req_valid[i] && req_ready[i]) |=>
        ctl_word[i*SLOT_W +: SLOT_W] == $past({req_sel[i*SEL_W +: SEL_W], req_cmd[i*CMD_W +: CMD_W]}));
    if (i < LANES - 1) begin : g_ord
      assert_ready_ordered_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid[i] && !req_ready[i]) |-> !req_ready[i+1]);
    end
  end
endmodule

bind ddr_slot_packer ddr_slot_packer_chk #(
  .LANES(LANES), .CMD_W(CMD_W), .SEL_W(SEL_W), .SEQ_W(SEQ_W),
  .CMD_NOP(CMD_NOP), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_sel(req_sel), .req_ready(req_ready), .ctl_word(ctl_word)
);

// File: tb/sim_ddr_slot_packer.sv
module sim_ddr_slot_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req_valid = '0;
  logic [11:0] req_cmd = '0;
  logic [19:0] req_sel = '0;
  logic [3:0]  req_ready;
  logic [35:0] ctl_word;
  logic        ctl_wr_en;
  logic        dram_rst_in = 1'b0;
  logic        dram_rst_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0]  exp_seq;
  logic [3:0]  exp_ready;
  logic [35:0] exp_word;

  always #2.5 clk = ~clk;

  ddr_slot_packer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_sel(req_sel), .req_ready(req_ready), .ctl_word(ctl_word),
    .ctl_wr_en(ctl_wr_en), .dram_rst_in(dram_rst_in), .dram_rst_n(dram_rst_n)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int pat, input int salt);
    int first_dir, cut;
    logic [2:0] c;
    logic [4:0] s;
    exp_ready = '0;
    exp_word  = '0;
    first_dir = 0;
    cut = 4;
    for (int i = 0; i < 4; i++) begin
      int k;
      k = (pat >> (2*i)) & 3;
      c = (k == 1) ? 3'b100 : (k == 2) ? 3'b101 : 3'b011;
      s = 5'((salt * 7 + i * 11 + pat) % 32);
      req_valid[i] = (k != 0);
      req_cmd[3*i +: 3] = (k == 0) ? 3'b111 : c;
      req_sel[5*i +: 5] = s;
      if (cut == 4 && (k == 1 || k == 2)) begin
        if (first_dir == 0) first_dir = k;
        else if (first_dir != k) cut = i;
      end
      exp_word[8*i +: 8] = 8'h07;
      if (i < cut) begin
        exp_ready[i] = 1'b1;
        if (k != 0) exp_word[8*i +: 8] = {s, c};
      end
    end
    exp_word[33:32] = 2'(first_dir);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req_valid = 4'hF; req_cmd = {4{3'b100}};
    #1;
    check("R8 ready in reset", 64'(req_ready), 64'h0);
    check("R8 word in reset", 64'(ctl_word), 64'h0_0_07070707);
    check("R1 wr_en in reset", 64'(ctl_wr_en), 64'h1);
    dram_rst_in = 1'b1; #1;
    check("R9 dram reset asserted", 64'(dram_rst_n), 64'h0);
    @(negedge clk);
    rst = 1'b0;
    exp_seq = 2'd0;
    for (int p = 0; p < 256; p++) begin
      drive(p, p / 3);
      if (p == 100) dram_rst_in = 1'b0;
      #1;
      check("R6 R7 ready pattern", 64'(req_ready), 64'(exp_ready));
      if (p == 100) check("R9 dram reset released", 64'(dram_rst_n), 64'h1);
      @(negedge clk);
      exp_seq = exp_seq + 2'd1;
      exp_word[35:34] = exp_seq;
      check("R2 R3 R4 R5 word", 64'(ctl_word), 64'(exp_word));
      check("R1 wr_en", 64'(ctl_wr_en), 64'h1);
    end
    drive(8'b01_01_01_01, 9);
    rst = 1'b1;
    #1;
    check("R8 ready mid-run reset", 64'(req_ready), 64'h0);
    @(negedge clk);
    check("R8 word after mid-run reset", 64'(ctl_word), 64'h0_0_07070707);
    check("R9 dram pin ignores rst", 64'(dram_rst_n), 64'h1);
    rst = 1'b0;
    drive(8'b00_00_00_00, 0);
    @(negedge clk);
    check("R4 first tag after reset", 64'(ctl_word[35:34]), 64'h1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule